// File: doc/BRIEF.md
# PCIe Root Port Reset and Link Power Sequencer

This block is the control-path sequencer that brings a PCIe root port out of reset and later parks its link in a low-power state. It has four reset lines: the controller MAC, the PHY, the bridge logic and the endpoint reset (PERST#). When a start request arrives, it asserts all four together and holds them for a power and clock settling interval. It then releases all four in the same cycle and waits a bounded time for the link to report that it is up. If the link does not come up in time, the sequence ends in a sticky error.

Once the link is up, a suspend request makes the block send a one-cycle turn-off command to the link layer. It then watches the 5-bit link training state for the L2 idle code. When that code appears, only the endpoint reset is asserted again and the port is considered suspended. If the code does not appear in time, the block reports an error instead. A new start request from the suspended or error state runs the full reset hold again.

All intervals are counted in clock cycles and set by parameters. At 50 MHz the defaults give a 100 ms hold, a 100 ms link-up limit and a 50 ms limit for reaching L2 idle.

Top module: `pcie_port_seq`

## Requirements
- R1: After synchronous reset, `rst_ctl` is 4'b1111 (all four resets asserted), and `link_off`, `seq_done` and `seq_error` are 0.
- R2: A start request is accepted in the idle, suspended or error state. From the next cycle, `rst_ctl` is 4'b1111 for exactly HOLD_CYCLES cycles. It then becomes 4'b0000, with all four bits changing in the same cycle. Bit 0 is the MAC reset, bit 1 the PHY reset, bit 2 the bridge reset and bit 3 the endpoint reset, and 1 means asserted.
- R3: After the release, the block waits for `link_up`. If `link_up` is sampled high on any of the first LINK_WAIT_CYCLES clock edges, `seq_done` goes to 1 in the next cycle. This includes the last edge of that window: on that edge `link_up` takes priority over the timeout.
- R4: If `link_up` stays low for LINK_WAIT_CYCLES edges after the release, `seq_error` goes to 1 and `rst_ctl` stays 4'b0000.
- R5: A suspend request while `seq_done` is 1 raises `link_off` for exactly one cycle, the cycle after acceptance. In that same cycle `seq_done` goes to 0.
- R6: While the block waits for L2 idle, an `ltssm_state` value of 5'h14 sampled on an edge sets `rst_ctl` to 4'b1000 in the next cycle. Only the endpoint reset is reasserted, and `seq_done` and `seq_error` stay 0.
- R7: If 5'h14 is not sampled within L2_WAIT_CYCLES edges after the suspend is accepted, `seq_error` goes to 1 and the endpoint reset stays released (`rst_ctl` is 4'b0000).
- R8: `seq_error` stays at 1 until a start request is accepted. That acceptance clears it in the next cycle and starts the full hold of R2.
- R9: A start request during the hold, the link wait, link-up or the L2 wait has no effect. A suspend request in any state other than link-up has no effect. `link_off` is high only in the cycle after an accepted suspend.
- R10: While the block waits for L2 idle, any `ltssm_state` value other than 5'h14 leaves `rst_ctl` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_req | input | 1 | Request to run the power-up reset sequence |
| suspend_req | input | 1 | Request to move the link to L2 and park the endpoint |
| link_up | input | 1 | Link-up indication from the controller |
| ltssm_state | input | 5 | Current link training state code |
| rst_ctl | output | 4 | Reset lines, 1 = asserted: bit 0 MAC, 1 PHY, 2 bridge, 3 endpoint |
| link_off | output | 1 | One-cycle command to turn the link off |
| seq_done | output | 1 | Link is up and the sequence is complete |
| seq_error | output | 1 | Sticky failure: link-up or L2 idle timeout |

## Verification
Every output is registered, so each result appears one cycle after the edge that samples its cause. The all-asserted reset vector appears the cycle after a start request is accepted. It flips to released HOLD_CYCLES cycles later. Done or error appears one cycle after the edge that saw `link_up` or reached the final timeout edge, and the turn-off pulse lasts only the cycle after the accepted suspend. The bench drives inputs and samples outputs on the falling edge. Its behavioural model advances on the rising edge, and the bench compares against that model on every cycle. Directed checks sit at the exact falling edges where these counts say each change is due, including the last edge of the link-up window.

// File: rtl/pps_pkg.sv
// Package: shared types and constants for the port reset/link-power sequencer.
// Assumes: a reset vector of four lines with the endpoint reset on the top bit.
package pps_pkg;

    localparam int NUM_RST    = 4;
    localparam int RST_MAC    = 0;
    localparam int RST_PHY    = 1;
    localparam int RST_BRIDGE = 2;
    localparam int RST_EP     = 3;

    localparam int        LTSSM_W   = 5;
    localparam logic [4:0] L2_IDLE  = 5'h14;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_HOLD  = 3'd1,
        ST_WLINK = 3'd2,
        ST_UP    = 3'd3,
        ST_WL2   = 3'd4,
        ST_SUSP  = 3'd5,
        ST_ERR   = 3'd6
    } seq_state_t;

    typedef enum logic [1:0] {
        RC_KEEP    = 2'd0,
        RC_ALL_ON  = 2'd1,
        RC_ALL_OFF = 2'd2,
        RC_EP_ON   = 2'd3
    } rst_cmd_t;

endpackage

// File: rtl/pps_interval_timer.sv
// Module: loadable down-counter used for the hold interval and both timeouts.
// Assumes: the controller loads (interval - 1); zero flags the final cycle.
module pps_interval_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             cnt_zero
);

    logic [CNT_W-1:0] cnt_q;

    // Load a fresh interval or count down, stopping at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Flag the last cycle of the interval.
    always_comb cnt_zero = (cnt_q == '0);

endmodule

// File: rtl/pps_l2_watch.sv
// Module: decodes the link training state and flags the L2 idle code.
// Assumes: the state code is already synchronous to clk.
module pps_l2_watch
    import pps_pkg::*;
(
    input  logic [LTSSM_W-1:0] ltssm_state,
    output logic               l2_hit
);

    // Compare the current training state with the L2 idle code.
    always_comb l2_hit = (ltssm_state == L2_IDLE);

endmodule

// File: rtl/pps_reset_bank.sv
// Module: register holding the reset lines (1 = asserted), one flop per line.
// Assumes: a single command per cycle; lines power up asserted.
module pps_reset_bank
    import pps_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  rst_cmd_t           cmd,
    output logic [NUM_RST-1:0] rst_lines
);

    for (genvar i = 0; i < NUM_RST; i++) begin : g_line
        // Apply the command to line i; only the endpoint line follows RC_EP_ON.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rst_lines[i] <= 1'b1;
            end else begin
                case (cmd)
                    RC_ALL_ON:  rst_lines[i] <= 1'b1;
                    RC_ALL_OFF: rst_lines[i] <= 1'b0;
                    RC_EP_ON:   if (i == RST_EP) rst_lines[i] <= 1'b1;
                    default:    rst_lines[i] <= rst_lines[i];
                endcase
            end
        end
    end

endmodule

// File: rtl/pps_ctrl_fsm.sv
// Module: sequencing state machine for power-up, link wait and suspend.
// Assumes: the timer is loaded with (interval - 1) on each state entry that
// needs one, and cnt_zero marks the last permitted cycle.
module pps_ctrl_fsm
    import pps_pkg::*;
#(
    parameter int              CNT_W   = 8,
    parameter logic [CNT_W-1:0] HOLD_LD = '0,
    parameter logic [CNT_W-1:0] LINK_LD = '0,
    parameter logic [CNT_W-1:0] L2_LD   = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic             suspend_req,
    input  logic             link_up,
    input  logic             l2_hit,
    input  logic             tmr_zero,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output rst_cmd_t         rst_cmd,
    output logic             link_off,
    output logic             seq_done,
    output logic             seq_error
);

    seq_state_t cur_q, nxt;
    logic       off_set, err_set, err_clr;
    logic       off_q, err_q;

    // Next-state and command decode.
    always_comb begin
        nxt      = cur_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        rst_cmd  = RC_KEEP;
        off_set  = 1'b0;
        err_set  = 1'b0;
        err_clr  = 1'b0;
        case (cur_q)
            ST_IDLE, ST_SUSP, ST_ERR: begin
                if (start_req) begin
                    nxt      = ST_HOLD;
                    tmr_load = 1'b1;
                    tmr_val  = HOLD_LD;
                    rst_cmd  = RC_ALL_ON;
                    err_clr  = 1'b1;
                end
            end
            ST_HOLD: begin
                if (tmr_zero) begin
                    nxt      = ST_WLINK;
                    tmr_load = 1'b1;
                    tmr_val  = LINK_LD;
                    rst_cmd  = RC_ALL_OFF;
                end
            end
            ST_WLINK: begin
                if (link_up) begin
                    nxt = ST_UP;
                end else if (tmr_zero) begin
                    nxt     = ST_ERR;
                    err_set = 1'b1;
                end
            end
            ST_UP: begin
                if (suspend_req) begin
                    nxt      = ST_WL2;
                    tmr_load = 1'b1;
                    tmr_val  = L2_LD;
                    off_set  = 1'b1;
                end
            end
            ST_WL2: begin
                if (l2_hit) begin
                    nxt     = ST_SUSP;
                    rst_cmd = RC_EP_ON;
                end else if (tmr_zero) begin
                    nxt     = ST_ERR;
                    err_set = 1'b1;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= ST_IDLE;
        else        cur_q <= nxt;
    end

    // Turn-off command: high only for the cycle after an accepted suspend.
    always_ff @(posedge clk) begin
        if (!rst_n) off_q <= 1'b0;
        else        off_q <= off_set;
    end

    // Sticky error flag, cleared only by an accepted start request.
    always_ff @(posedge clk) begin
        if (!rst_n)       err_q <= 1'b0;
        else if (err_clr) err_q <= 1'b0;
        else if (err_set) err_q <= 1'b1;
    end

    // Status outputs.
    always_comb begin
        link_off  = off_q;
        seq_error = err_q;
        seq_done  = (cur_q == ST_UP);
    end

endmodule

// File: rtl/pcie_port_seq.sv
// Module: top of the root-port reset and link-power sequencer.
// Assumes: all inputs synchronous to clk; every interval is at least one cycle.
module pcie_port_seq
    import pps_pkg::*;
#(
    parameter int HOLD_CYCLES      = 5_000_000,
    parameter int LINK_WAIT_CYCLES = 5_000_000,
    parameter int L2_WAIT_CYCLES   = 2_500_000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_req,
    input  logic         suspend_req,
    input  logic         link_up,
    input  logic [4:0]   ltssm_state,
    output logic [3:0]   rst_ctl,
    output logic         link_off,
    output logic         seq_done,
    output logic         seq_error
);

    localparam int MAX_A  = (HOLD_CYCLES > LINK_WAIT_CYCLES) ? HOLD_CYCLES : LINK_WAIT_CYCLES;
    localparam int MAX_IV = (MAX_A > L2_WAIT_CYCLES) ? MAX_A : L2_WAIT_CYCLES;
    localparam int CNT_W  = (MAX_IV > 1) ? $clog2(MAX_IV) : 1;
    localparam logic [CNT_W-1:0] HOLD_LD = CNT_W'(HOLD_CYCLES - 1);
    localparam logic [CNT_W-1:0] LINK_LD = CNT_W'(LINK_WAIT_CYCLES - 1);
    localparam logic [CNT_W-1:0] L2_LD   = CNT_W'(L2_WAIT_CYCLES - 1);

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;
    logic             l2_hit;
    rst_cmd_t         rst_cmd;

    pps_l2_watch u_l2 (
        .ltssm_state (ltssm_state),
        .l2_hit      (l2_hit)
    );

    pps_interval_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .cnt_zero (tmr_zero)
    );

    pps_ctrl_fsm #(
        .CNT_W   (CNT_W),
        .HOLD_LD (HOLD_LD),
        .LINK_LD (LINK_LD),
        .L2_LD   (L2_LD)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_req   (start_req),
        .suspend_req (suspend_req),
        .link_up     (link_up),
        .l2_hit      (l2_hit),
        .tmr_zero    (tmr_zero),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .rst_cmd     (rst_cmd),
        .link_off    (link_off),
        .seq_done    (seq_done),
        .seq_error   (seq_error)
    );

    pps_reset_bank u_rst (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (rst_cmd),
        .rst_lines (rst_ctl)
    );

endmodule

// File: rtl/pps_seq_checker.sv
// Module: port-level properties of the sequencer, bound to the top module.
// Assumes: synchronous active-low reset; all properties disabled while it is low.
module pps_seq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start_req,
    input logic       suspend_req,
    input logic [4:0] ltssm_state,
    input logic [3:0] rst_ctl,
    input logic       link_off,
    input logic       seq_done,
    input logic       seq_error
);

    // R2 / R6: only all-on, all-off or endpoint-only reset patterns exist.
    a_r2_lines_together: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_ctl == 4'hF) || (rst_ctl == 4'h0) || (rst_ctl == 4'h8));

    // R5: the turn-off command never lasts two cycles.
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        link_off |=> !link_off);

    // R9: the turn-off command follows a suspend request made while done.
    a_r9_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
        link_off |-> ($past(suspend_req) && $past(seq_done)));

    // R6: endpoint reset reasserts from all-released only after L2 idle.
    a_r6_perst_on_l2: assert property (@(posedge clk) disable iff (!rst_n)
        ((rst_ctl == 4'h8) && $past(rst_ctl == 4'h0)) |-> ($past(ltssm_state) == 5'h14));

    // R4 / R7: an error never comes with any reset line asserted.
    a_r4_error_released: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_error) |-> (rst_ctl == 4'h0));

    // R8: the error stays until a start request arrives.
    a_r8_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_error && !start_req) |=> seq_error);

    // R3: done and error are never both high.
    a_r3_done_xor_error: assert property (@(posedge clk) disable iff (!rst_n)
        !(seq_done && seq_error));

endmodule

bind pcie_port_seq pps_seq_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_req   (start_req),
    .suspend_req (suspend_req),
    .ltssm_state (ltssm_state),
    .rst_ctl     (rst_ctl),
    .link_off    (link_off),
    .seq_done    (seq_done),
    .seq_error   (seq_error)
);

// File: tb/pcie_port_seq_test.sv
// Bench: behavioural reference model compared every cycle, plus directed checks.
module pcie_port_seq_test;

    localparam int HOLD = 6;
    localparam int LINK = 8;
    localparam int L2W  = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_req = 1'b0;
    logic       suspend_req = 1'b0;
    logic       link_up = 1'b0;
    logic [4:0] ltssm_state = 5'h0;
    logic [3:0] rst_ctl;
    logic       link_off, seq_done, seq_error;

    int n_checks = 0;
    int n_fail   = 0;
    bit cmp_en   = 1'b0;
    bit finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    pcie_port_seq #(
        .HOLD_CYCLES      (HOLD),
        .LINK_WAIT_CYCLES (LINK),
        .L2_WAIT_CYCLES   (L2W)
    ) uut (
        .clk (clk), .rst_n (rst_n), .start_req (start_req),
        .suspend_req (suspend_req), .link_up (link_up),
        .ltssm_state (ltssm_state), .rst_ctl (rst_ctl),
        .link_off (link_off), .seq_done (seq_done), .seq_error (seq_error)
    );

    // Reference model: phase 0 idle, 1 hold, 2 link wait, 3 up, 4 L2 wait, 5 parked, 6 failed.
    int         m_phase = 0;
    int         m_elapsed = 0;
    logic [3:0] m_rst = 4'hF;
    logic       m_off = 1'b0;
    logic       m_err = 1'b0;
    string      m_tag = "R1";

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_rst = 4'hF; m_off = 1'b0; m_err = 1'b0; m_tag = "R1";
        end else begin
            m_off = 1'b0;
            case (m_phase)
                0, 5, 6: if (start_req) begin
                    m_phase = 1; m_rst = 4'hF; m_err = 1'b0; m_elapsed = 0; m_tag = "R2";
                end
                1: begin
                    m_elapsed++;
                    if (m_elapsed == HOLD) begin
                        m_phase = 2; m_rst = 4'h0; m_elapsed = 0; m_tag = "R3";
                    end
                end
                2: if (link_up) m_phase = 3;
                   else begin
                       m_elapsed++;
                       if (m_elapsed == LINK) begin m_phase = 6; m_err = 1'b1; m_tag = "R4"; end
                   end
                3: if (suspend_req) begin
                    m_phase = 4; m_off = 1'b1; m_elapsed = 0; m_tag = "R5";
                end
                4: if (ltssm_state == 5'h14) begin
                       m_phase = 5; m_rst[3] = 1'b1; m_tag = "R6";
                   end else begin
                       m_elapsed++;
                       if (m_elapsed == L2W) begin m_phase = 6; m_err = 1'b1; m_tag = "R7"; end
                   end
                default: ;
            endcase
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the rising edge.
    always @(negedge clk) begin
        if (cmp_en) begin
            check({m_tag, " rst_ctl"}, {28'd0, rst_ctl}, {28'd0, m_rst});
            check({m_tag, " link_off"}, {31'd0, link_off}, {31'd0, m_off});
            check({m_tag, " done"}, {31'd0, seq_done}, {31'd0, (m_phase == 3)});
            check({m_tag, " error"}, {31'd0, seq_error}, {31'd0, m_err});
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic req_start();
        start_req = 1'b1; tick(1); start_req = 1'b0;
    endtask

    task automatic req_suspend();
        suspend_req = 1'b1; tick(1); suspend_req = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        cmp_en = 1'b1;
        // R1: reset state
        check("R1 rst_ctl", {28'd0, rst_ctl}, 32'hF);
        check("R1 flags", {29'd0, link_off, seq_done, seq_error}, 32'h0);

        // R2: hold for exactly HOLD cycles, then release together
        req_start();
        check("R2 hold start", {28'd0, rst_ctl}, 32'hF);
        tick(HOLD - 1);
        check("R2 hold last", {28'd0, rst_ctl}, 32'hF);
        tick(1);
        check("R2 release", {28'd0, rst_ctl}, 32'h0);

        // R3: link up mid-window
        tick(2);
        link_up = 1'b1;
        tick(1);
        check("R3 done", {31'd0, seq_done}, 32'h1);

        // R9: start ignored while up
        req_start();
        check("R9 start ignored", {27'd0, seq_done, rst_ctl}, 32'h10);

        // R5: turn-off pulse
        req_suspend();
        check("R5 pulse", {30'd0, link_off, seq_done}, 32'h2);
        ltssm_state = 5'h13;
        tick(1);
        check("R5 pulse end", {31'd0, link_off}, 32'h0);
        tick(1);
        check("R10 non-L2 code", {28'd0, rst_ctl}, 32'h0);
        ltssm_state = 5'h14;
        tick(1);
        check("R6 endpoint only", {28'd0, rst_ctl}, 32'h8);
        check("R6 flags", {30'd0, seq_done, seq_error}, 32'h0);
        ltssm_state = 5'h0;
        link_up = 1'b0;

        // R8 / R2: restart from parked, then link timeout R4
        req_start();
        check("R8 restart hold", {28'd0, rst_ctl}, 32'hF);
        tick(HOLD);
        tick(LINK - 1);
        check("R4 before limit", {31'd0, seq_error}, 32'h0);
        tick(1);
        check("R4 timeout", {27'd0, seq_error, rst_ctl}, 32'h10);

        // R8 / R9: error sticky, suspend ignored
        suspend_req = 1'b1; tick(3); suspend_req = 1'b0;
        check("R8 sticky", {31'd0, seq_error}, 32'h1);
        check("R9 no pulse", {31'd0, link_off}, 32'h0);

        // R8: start clears error; R3 on first wait edge; R7 L2 timeout
        req_start();
        check("R8 cleared", {27'd0, seq_error, rst_ctl}, 32'h0F);
        tick(HOLD);
        link_up = 1'b1;
        tick(1);
        check("R3 immediate", {31'd0, seq_done}, 32'h1);
        req_suspend();
        tick(L2W - 1);
        check("R7 before limit", {31'd0, seq_error}, 32'h0);
        tick(1);
        check("R7 timeout", {27'd0, seq_error, rst_ctl}, 32'h10);
        link_up = 1'b0;

        // R3 boundary: link up on the last permitted edge
        req_start();
        tick(HOLD);
        tick(LINK - 1);
        link_up = 1'b1;
        tick(1);
        check("R3 last edge", {30'd0, seq_done, seq_error}, 32'h2);
        link_up = 1'b0;
        tick(3);
        finish_run();
    end

endmodule